// File: doc/BRIEF.md
# Synthesizer divider chain

This block holds the digital dividers of a PLL frequency synthesizer. The reference side is clocked by the input clock. A fixed divide-by-16 prescaler turns that clock into the phase-detector reference. The VCO side is clocked by the fast VCO-rate clock and holds two dividers:

- The feedback divider is a fixed divide-by-2 stage followed by a programmable divide-by-M counter. At lock this gives fVCO = fIN x 2M / 16.
- The output divider divides the VCO clock by a ratio selected from a 3-bit code and keeps a 50% duty cycle.

The phase detector, loop filter and VCO lie outside the block.

Each VCO-side divider is a small state machine. The feedback divider has three states:

- `FB_HOLD`: M is invalid. The feedback clock is held low.
- `FB_HI`: the high half of the feedback period.
- `FB_LO`: the low half of the feedback period.

Its transitions are:

- HOLD->HI: a valid M is seen.
- HI->LO: the high half ends.
- LO->HI: terminal count, reload with a valid M.
- LO->HOLD: terminal count, reload with an invalid M.

The output divider has four states:

- `OD_OFF`: reset.
- `OD_BYP`: divide-by-1, the VCO clock passes straight through.
- `OD_HI`: the high half of the output period.
- `OD_LO`: the low half of the output period.

Its transitions are:

- OFF->HI or OFF->BYP: first cycle after reset.
- HI->LO: the high half ends.
- LO->HI or LO->BYP: terminal count with reload.
- BYP->BYP or BYP->HI: every bypass cycle is a terminal count.

Both dividers sample a new ratio only at a terminal count.

Top module: `syn_div_chain`

## Requirements
- R1: The reference output divides the input clock by 16. It is high for 8 input-clock cycles and low for 8, starting low after reset.
- R2: For M from 2 to 511, the feedback output has a period of 2M VCO cycles. It is high for 2*ceil(M/2) of those cycles and low for 2*floor(M/2).
- R3: An M of 0 or 1 holds the feedback counter in reset and keeps the feedback output low. A later valid M restarts it with the correct period.
- R4: The output divider ratio is set by the 3-bit code as follows: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 100 gives 6, 101 gives 10, 110 gives 12. For every ratio of 2 or more, the output is high for half the ratio and low for half, counted in VCO cycles.
- R5: With code 000, the output clock follows the VCO clock. It is high in the high phase of the VCO clock and low in the low phase.
- R6: Code 111 is unsupported and selects divide-by-2.
- R7: A change of M or of the code takes effect only at the divider's terminal count. The period in progress completes with the old ratio, so no runt pulse appears.
- R8: While the active-high synchronous reset is asserted, all counters are cleared and all three outputs are low, including when code 000 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | VCO-rate clock for the feedback and output dividers |
| ref_clk | input | 1 | Input reference clock for the prescaler |
| rst | input | 1 | Active-high synchronous reset, sampled in both clock domains |
| m_val | input | 9 | Feedback divide value M |
| n_code | input | 3 | Output divider code |
| ref_div_out | output | 1 | Reference clock to the phase detector (input / 16) |
| fb_clk_out | output | 1 | Feedback clock (VCO / 2M) |
| out_clk | output | 1 | Scaled output clock (VCO / N) |

## Verification
The assertions check the following on every cycle:

- The active ratios stay frozen everywhere except at a terminal count.
- The divide-by-2 phase bit toggles on every running cycle.
- The output counter stays inside its half-ratio window.
- The feedback clock is low whenever the feedback state machine is holding.
- The reference rises only at mid-count.
- Reset forces the outputs low.

Some behaviours can only be shown by the bench's scenarios:

- The actual high and low lengths for each M and code.
- The divide-by-1 pass-through waveform.
- The default ratio for the unsupported code.
- That a mid-period reconfiguration finishes the old period before the new ratio appears.

// File: rtl/syn_div_pkg.sv
package syn_div_pkg;

    localparam int M_W = 9;
    localparam int N_W = 3;
    localparam int R_W = 4;

    typedef enum logic [1:0] {
        OD_OFF = 2'd0,
        OD_BYP = 2'd1,
        OD_HI  = 2'd2,
        OD_LO  = 2'd3
    } od_state_t;

    typedef enum logic [1:0] {
        FB_HOLD = 2'd0,
        FB_HI   = 2'd1,
        FB_LO   = 2'd2
    } fb_state_t;

    // Output divider code to divide ratio; unsupported code falls back to 2.
    function automatic logic [R_W-1:0] n_ratio(input logic [N_W-1:0] code);
        logic [R_W-1:0] r;
        case (code)
            3'd0:    r = R_W'(1);
            3'd1:    r = R_W'(2);
            3'd2:    r = R_W'(4);
            3'd3:    r = R_W'(8);
            3'd4:    r = R_W'(6);
            3'd5:    r = R_W'(10);
            3'd6:    r = R_W'(12);
            default: r = R_W'(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/syn_ref_prescale.sv
module syn_ref_prescale #(
    parameter int PRE_DIV = 16
) (
    input  logic ref_clk,
    input  logic rst,
    output logic ref_div
);
    localparam int CW   = $clog2(PRE_DIV);
    localparam int HALF = PRE_DIV / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;

    assign cnt_n = (cnt == CW'(PRE_DIV - 1)) ? '0 : cnt + CW'(1);

    always_ff @(posedge ref_clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_n;
    end

    generate
        if ((PRE_DIV & (PRE_DIV - 1)) == 0) begin : g_pow2
            assign ref_div = cnt[CW-1];
        end else begin : g_general
            logic ref_q;
            always_ff @(posedge ref_clk) begin
                if (rst) ref_q <= 1'b0;
                else     ref_q <= (cnt_n >= CW'(HALF));
            end
            assign ref_div = ref_q;
        end
    endgenerate

    // R1
    ref_mid_rise_chk: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(ref_div) |-> (cnt == CW'(HALF)));

    // R8
    ref_reset_chk: assert property (@(posedge ref_clk)
        rst |=> (cnt == '0));

endmodule

// File: rtl/syn_fb_div.sv
module syn_fb_div
    import syn_div_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_val,
    output logic           fb_clk
);
    fb_state_t      st, st_n;
    logic [M_W-1:0] tick, tick_n;
    logic [M_W-1:0] act_m, act_m_n;
    logic           pre2, pre2_n;
    logic           load;
    logic           fb_q;

    function automatic logic [M_W-1:0] hi_m1(input logic [M_W-1:0] m);
        return (m - M_W'(1)) >> 1;
    endfunction

    function automatic logic [M_W-1:0] lo_m1(input logic [M_W-1:0] m);
        return (m >> 1) - M_W'(1);
    endfunction

    always_comb begin
        st_n    = st;
        tick_n  = tick;
        act_m_n = act_m;
        pre2_n  = pre2;
        load    = 1'b0;
        unique case (st)
            FB_HOLD: load = 1'b1;
            FB_HI: begin
                pre2_n = ~pre2;
                if (pre2) begin
                    if (tick == '0) begin
                        st_n   = FB_LO;
                        tick_n = lo_m1(act_m);
                    end else begin
                        tick_n = tick - M_W'(1);
                    end
                end
            end
            FB_LO: begin
                pre2_n = ~pre2;
                if (pre2) begin
                    if (tick == '0) load = 1'b1;
                    else            tick_n = tick - M_W'(1);
                end
            end
            default: st_n = FB_HOLD;
        endcase
        if (load) begin
            act_m_n = m_val;
            pre2_n  = 1'b0;
            if (m_val < M_W'(2)) begin
                st_n   = FB_HOLD;
                tick_n = '0;
            end else begin
                st_n   = FB_HI;
                tick_n = hi_m1(m_val);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= FB_HOLD;
            tick  <= '0;
            act_m <= '0;
            pre2  <= 1'b0;
        end else begin
            st    <= st_n;
            tick  <= tick_n;
            act_m <= act_m_n;
            pre2  <= pre2_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fb_q <= 1'b0;
        else     fb_q <= (st_n == FB_HI);
    end

    assign fb_clk = fb_q;

    // R3
    fb_hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st == FB_HOLD) |-> !fb_q);

    // R2
    fb_half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (st != FB_HOLD && $past(st) != FB_HOLD) |-> (pre2 != $past(pre2)));

    // R7
    fb_m_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (st == FB_HI) |=> $stable(act_m));

endmodule

// File: rtl/syn_out_div.sv
module syn_out_div
    import syn_div_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_code,
    output logic           div_q,
    output logic           bypass
);
    od_state_t      st, st_n;
    logic [R_W-1:0] cnt, cnt_n;
    logic [R_W-1:0] act_r, act_r_n;
    logic [R_W-1:0] new_r;
    logic           term;
    logic           out_q;

    assign new_r = n_ratio(n_code);

    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        act_r_n = act_r;
        term    = 1'b0;
        unique case (st)
            OD_OFF, OD_BYP: term = 1'b1;
            OD_HI: begin
                if (cnt == '0) begin
                    st_n  = OD_LO;
                    cnt_n = (act_r >> 1) - R_W'(1);
                end else begin
                    cnt_n = cnt - R_W'(1);
                end
            end
            OD_LO: begin
                if (cnt == '0) term = 1'b1;
                else           cnt_n = cnt - R_W'(1);
            end
            default: st_n = OD_OFF;
        endcase
        if (term) begin
            act_r_n = new_r;
            if (new_r == R_W'(1)) begin
                st_n  = OD_BYP;
                cnt_n = '0;
            end else begin
                st_n  = OD_HI;
                cnt_n = (new_r >> 1) - R_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= OD_OFF;
            cnt   <= '0;
            act_r <= '0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            act_r <= act_r_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= (st_n == OD_HI);
    end

    assign div_q  = out_q;
    assign bypass = (st == OD_BYP);

    // R7
    od_ratio_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (st == OD_HI || (st == OD_LO && cnt != '0)) |=> $stable(act_r));

    // R4
    od_cnt_window_chk: assert property (@(posedge clk) disable iff (rst)
        (st == OD_HI || st == OD_LO) |-> (cnt < (act_r >> 1)));

    // R8
    od_reset_low_chk: assert property (@(posedge clk)
        rst |=> (!out_q && st == OD_OFF));

endmodule

// File: rtl/syn_div_chain.sv
module syn_div_chain
    import syn_div_pkg::*;
#(
    parameter int PRE_DIV = 16
) (
    input  logic           vco_clk,
    input  logic           ref_clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_val,
    input  logic [N_W-1:0] n_code,
    output logic           ref_div_out,
    output logic           fb_clk_out,
    output logic           out_clk
);
    logic od_q;
    logic od_byp;

    syn_ref_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .ref_clk (ref_clk),
        .rst     (rst),
        .ref_div (ref_div_out)
    );

    syn_fb_div u_fb (
        .clk    (vco_clk),
        .rst    (rst),
        .m_val  (m_val),
        .fb_clk (fb_clk_out)
    );

    syn_out_div u_od (
        .clk    (vco_clk),
        .rst    (rst),
        .n_code (n_code),
        .div_q  (od_q),
        .bypass (od_byp)
    );

    assign out_clk = od_byp ? vco_clk : od_q;

endmodule

// File: tb/syn_div_chain_tb_top.sv
`timescale 1ns/1ps
module syn_div_chain_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 40;
    localparam int NVEC       = 7;
    localparam int LIMIT      = 3000;

    // {M[8:0], code[2:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {9'd2,   3'd1},
        {9'd3,   3'd2},
        {9'd8,   3'd3},
        {9'd5,   3'd4},
        {9'd7,   3'd5},
        {9'd16,  3'd6},
        {9'd511, 3'd7}
    };

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst     = 1'b1;
    logic [8:0] m_val   = 9'd4;
    logic [2:0] n_code  = 3'd1;
    logic       ref_div_out, fb_clk_out, out_clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) vco_clk = ~vco_clk;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    syn_div_chain dut_i (
        .vco_clk     (vco_clk),
        .ref_clk     (ref_clk),
        .rst         (rst),
        .m_val       (m_val),
        .n_code      (n_code),
        .ref_div_out (ref_div_out),
        .fb_clk_out  (fb_clk_out),
        .out_clk     (out_clk)
    );

    function automatic int exp_ratio(input logic [2:0] c);
        case (c)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            3'd4:    return 6;
            3'd5:    return 10;
            3'd6:    return 12;
            default: return 2;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic samp(input int sel);
        return (sel == 0) ? fb_clk_out : out_clk;
    endfunction

    task automatic tick_s();
        @(posedge vco_clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic wait_rise(input int sel);
        logic prev;
        prev = samp(sel);
        for (int i = 0; i < LIMIT; i++) begin
            tick_s();
            if (!prev && samp(sel)) return;
            prev = samp(sel);
        end
    endtask

    // Counts high and low samples from a rise up to the next rise.
    task automatic count_rest(input int sel, output int hi, output int lo);
        hi = 1;
        lo = 0;
        for (int i = 0; i < LIMIT; i++) begin
            tick_s();
            if (samp(sel) && lo == 0)  hi++;
            else if (!samp(sel))       lo++;
            else                       break;
        end
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        repeat (10) tick_s();
        rst = 1'b0;
    endtask

    task automatic print_summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge vco_clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            print_summary();
            $finish;
        end
    end

    initial begin
        int hi, lo, cnt;
        logic prev;

        // R8: reset state, with code 000 selected to show bypass is gated
        n_code = 3'd0;
        rst    = 1'b1;
        repeat (10) tick_s();
        check("R8 ref low in reset", int'(ref_div_out), 0);
        check("R8 fb low in reset",  int'(fb_clk_out), 0);
        check("R8 out low in reset", int'(out_clk), 0);
        m_val  = 9'd4;
        n_code = 3'd1;
        rst    = 1'b0;

        // R1: reference divide by 16, high 8 / low 8 input cycles
        @(posedge ref_clk); #(REF_PERIOD/4);
        prev = ref_div_out;
        for (int i = 0; i < 64; i++) begin
            @(posedge ref_clk); #(REF_PERIOD/4);
            if (!prev && ref_div_out) break;
            prev = ref_div_out;
        end
        hi = 1; lo = 0;
        for (int i = 0; i < 64; i++) begin
            @(posedge ref_clk); #(REF_PERIOD/4);
            if (ref_div_out && lo == 0) hi++;
            else if (!ref_div_out)      lo++;
            else                        break;
        end
        check("R1 ref high", hi, 8);
        check("R1 ref low",  lo, 8);

        // R2 R4 R6: vector table
        for (int v = 0; v < NVEC; v++) begin
            int m, r;
            string rq;
            m_val  = VEC[v][11:3];
            n_code = VEC[v][2:0];
            m = int'(VEC[v][11:3]);
            r = exp_ratio(VEC[v][2:0]);
            rq = (VEC[v][2:0] == 3'd7) ? "R6 out" : "R4 out";
            apply_reset();
            wait_rise(0);
            count_rest(0, hi, lo);
            check("R2 fb high", hi, 2 * ((m + 1) / 2));
            check("R2 fb low",  lo, 2 * (m / 2));
            wait_rise(1);
            count_rest(1, hi, lo);
            check({rq, " high"}, hi, r / 2);
            check({rq, " low"},  lo, r / 2);
        end

        // R5: code 000 passes the VCO clock through
        n_code = 3'd0;
        apply_reset();
        repeat (2) tick_s();
        for (int i = 0; i < 6; i++) begin
            @(posedge vco_clk); #(CLK_PERIOD/4);
            check("R5 bypass high phase", int'(out_clk), 1);
            #(CLK_PERIOD/2);
            check("R5 bypass low phase", int'(out_clk), 0);
        end

        // R3: M = 1 from reset keeps feedback low
        m_val = 9'd1;
        apply_reset();
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            tick_s();
            if (fb_clk_out) cnt++;
        end
        check("R3 fb highs with M=1", cnt, 0);

        // R3: M = 0 written while running, then recovery with M = 6
        m_val = 9'd4;
        apply_reset();
        repeat (5) tick_s();
        m_val = 9'd0;
        repeat (20) tick_s();
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            tick_s();
            if (fb_clk_out) cnt++;
        end
        check("R3 fb highs with M=0", cnt, 0);
        m_val = 9'd6;
        wait_rise(0);
        count_rest(0, hi, lo);
        check("R3 fb high after recovery", hi, 6);
        check("R3 fb low after recovery",  lo, 6);

        // R7: output ratio change mid-period
        n_code = 3'd3;
        apply_reset();
        wait_rise(1);
        n_code = 3'd1;
        count_rest(1, hi, lo);
        check("R7 out old high", hi, 4);
        check("R7 out old low",  lo, 4);
        count_rest(1, hi, lo);
        check("R7 out new high", hi, 1);
        check("R7 out new low",  lo, 1);

        // R7: feedback M change mid-period
        m_val = 9'd6;
        apply_reset();
        wait_rise(0);
        m_val = 9'd3;
        count_rest(0, hi, lo);
        check("R7 fb old high", hi, 6);
        check("R7 fb old low",  lo, 6);
        count_rest(0, hi, lo);
        check("R7 fb new high", hi, 4);
        check("R7 fb new low",  lo, 2);

        done = 1'b1;
        print_summary();
        $finish;
    end

endmodule